// File: doc/BRIEF.md
# Ring-Oscillator Entropy Collector

This block is the front end of a true random number source. A bank of free-running oscillators toggles with no relation to the system clock. The block brings their outputs into the clock domain through a short flop chain. Once per sample interval it folds all the oscillator states into one parity bit. Two parity bits from consecutive intervals are combined into a single entropy bit, which is shifted into a 32-bit entropy word.

Software polls a status register for a ready bit and then reads the data register. Bits are collected all the time, with the oldest bit dropped as each new one arrives. Each read of the data register restarts the count, so a word is never reported ready until it holds a full set of bits that have not been seen before. In simulation the oscillator outputs are an ordinary input vector driven by the testbench.

Top module: `trng_collector`

## Requirements
- R1: After synchronous reset the entropy word and the collected-bit count are zero. A status read then returns 0 and a data read returns 0.
- R2: The oscillator vector passes through SYNC_STAGES flops. A sample is taken on every SAMPLE_CYCLES-th clock edge after reset, and its value is the XOR of all synchronized oscillator bits.
- R3: Samples are paired in order, first with second, third with fourth and so on. Each pair gives one entropy bit equal to the XOR of the two samples, so an oscillator vector that holds its parity constant yields 0 bits.
- R4: Each entropy bit enters the word at bit 0 while the older bits move one place toward bit 31. Bit 31 is discarded, so the data register always holds the latest 32 bits.
- R5: The status register (rd_addr = 0) returns the ready flag in bit 0 and zeros in bits 31:1. The flag is 1 once 32 bits have been collected since reset or since the last data read.
- R6: A data read (rd_addr = 1) clears the ready flag. The flag is set again only after 32 further bits. A bit that is shifted in during the read cycle counts toward those 32 and is not part of the word returned.
- R7: Collection continues while the flag is set. The bit count saturates at 32, and the flag stays set until a data read.
- R8: A read with rd_en high returns its value on rd_data in the next cycle. rd_data is zero after any cycle without a read. A status read does not change the flag or the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_i | input | NUM_OSC | Raw oscillator outputs, asynchronous to clk |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 1 | Register select: 0 status, 1 data |
| rd_data | output | WORD_W | Registered read data |

## Verification
The assertions assume that rd_en and rd_addr are stable, synchronous inputs. They also assume that osc_i, although asynchronous in a real device, holds a defined 0 or 1 on every bit. The bench keeps to this by changing every input only on the falling clock edge and by never driving X or Z onto the oscillator vector. It uses a short sample interval so that many words can be formed within the run. Its oscillator patterns include constant, random and parity-toggling vectors, which exercise both the cancelling and the non-cancelling cases of the pairwise fold.

// File: rtl/trng_pkg.sv
package trng_pkg;
    localparam int unsigned DEF_NUM_OSC       = 32;
    localparam int unsigned DEF_SAMPLE_CYCLES = 4096;
    localparam int unsigned DEF_WORD_W        = 32;
    localparam int unsigned DEF_SYNC_STAGES   = 2;

    typedef enum logic {
        REG_STATUS = 1'b0,
        REG_DATA   = 1'b1
    } reg_sel_e;

    // State of the sample pairing: which half of a pair is next and the held first half
    typedef struct packed {
        logic second;
        logic held;
    } pair_t;

    // One folded entropy bit with its valid strobe
    typedef struct packed {
        logic valid;
        logic value;
    } ebit_t;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction
endpackage

// File: rtl/trng_sync.sv
module trng_sync
    import trng_pkg::*;
#(
    parameter int unsigned NUM_OSC     = DEF_NUM_OSC,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_OSC-1:0] raw_i,
    output logic [NUM_OSC-1:0] sync_o
);
    generate
        if (SYNC_STAGES == 0) begin : g_bypass
            assign sync_o = raw_i;
        end else begin : g_chain
            logic [NUM_OSC-1:0] stage_q [SYNC_STAGES];
            for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst) begin
                        stage_q[s] <= '0;
                    end else if (s == 0) begin
                        stage_q[s] <= raw_i;
                    end else begin
                        stage_q[s] <= stage_q[s-1];
                    end
                end
            end
            assign sync_o = stage_q[SYNC_STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/trng_sampler.sv
module trng_sampler
    import trng_pkg::*;
#(
    parameter int unsigned NUM_OSC       = DEF_NUM_OSC,
    parameter int unsigned SAMPLE_CYCLES = DEF_SAMPLE_CYCLES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_OSC-1:0] osc_i,
    output ebit_t              ebit_o
);
    localparam int unsigned CNT_W = cnt_width(SAMPLE_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLE_CYCLES - 1);

    logic [CNT_W-1:0] tick_q;
    logic             sample_stb;
    logic             fold;
    pair_t            pair_q;
    ebit_t            ebit_q;

    assign sample_stb = (tick_q == LAST);
    assign fold       = ^osc_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
        end else if (sample_stb) begin
            tick_q <= '0;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
            ebit_q <= '0;
        end else begin
            ebit_q.valid <= 1'b0;
            if (sample_stb) begin
                if (pair_q.second) begin
                    ebit_q.value  <= pair_q.held ^ fold;
                    ebit_q.valid  <= 1'b1;
                    pair_q.second <= 1'b0;
                end else begin
                    pair_q.held   <= fold;
                    pair_q.second <= 1'b1;
                end
            end
        end
    end

    assign ebit_o = ebit_q;

    // R3
    ebit_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        ebit_q.valid |=> !ebit_q.valid);

    // R2
    sample_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_stb && SAMPLE_CYCLES > 1) |=> !sample_stb);

    // R3
    pair_order_chk: assert property (@(posedge clk) disable iff (rst)
        ebit_q.valid |-> !pair_q.second);
endmodule

// File: rtl/trng_packer.sv
module trng_packer
    import trng_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ebit_t             ebit_i,
    input  logic              clear_i,
    output logic [WORD_W-1:0] word_o,
    output logic              ready_o
);
    localparam int unsigned BCNT_W = $clog2(WORD_W + 1);
    localparam logic [BCNT_W-1:0] FULL = BCNT_W'(WORD_W);

    logic [WORD_W-1:0] word_q;
    logic [BCNT_W-1:0] bits_q;
    logic [BCNT_W-1:0] bits_base;

    assign bits_base = clear_i ? '0 : bits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            bits_q <= '0;
        end else begin
            if (ebit_i.valid) begin
                word_q <= {word_q[WORD_W-2:0], ebit_i.value};
            end
            if (ebit_i.valid && bits_base != FULL) begin
                bits_q <= bits_base + 1'b1;
            end else begin
                bits_q <= bits_base;
            end
        end
    end

    assign word_o  = word_q;
    assign ready_o = (bits_q == FULL);

    // R4
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        ebit_i.valid |=> word_q[0] == $past(ebit_i.value));

    // R4
    word_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ebit_i.valid |=> $stable(word_q));

    // R6
    clear_drop_chk: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> !ready_o);

    // R7
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !clear_i) |=> ready_o);

    // R5
    ready_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> $past(ebit_i.valid));
endmodule

// File: rtl/trng_regs.sv
module trng_regs
    import trng_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              rd_addr,
    input  logic [WORD_W-1:0] word_i,
    input  logic              ready_i,
    output logic              clear_o,
    output logic [WORD_W-1:0] rd_data
);
    reg_sel_e          sel;
    logic [WORD_W-1:0] rd_next;

    assign sel     = reg_sel_e'(rd_addr);
    assign clear_o = rd_en && (sel == REG_DATA);

    always_comb begin
        rd_next = '0;
        if (rd_en) begin
            unique case (sel)
                REG_STATUS: rd_next = {{(WORD_W-1){1'b0}}, ready_i};
                REG_DATA:   rd_next = word_i;
                default:    rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_next;
        end
    end

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rd_data == '0);

    // R5
    status_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == REG_STATUS) |=> rd_data[WORD_W-1:1] == '0);
endmodule

// File: rtl/trng_collector.sv
module trng_collector
    import trng_pkg::*;
#(
    parameter int unsigned NUM_OSC       = DEF_NUM_OSC,
    parameter int unsigned SAMPLE_CYCLES = DEF_SAMPLE_CYCLES,
    parameter int unsigned WORD_W        = DEF_WORD_W,
    parameter int unsigned SYNC_STAGES   = DEF_SYNC_STAGES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_OSC-1:0] osc_i,
    input  logic               rd_en,
    input  logic               rd_addr,
    output logic [WORD_W-1:0]  rd_data
);
    logic [NUM_OSC-1:0] osc_sync;
    ebit_t              ebit;
    logic               clear;
    logic               ready;
    logic [WORD_W-1:0]  word;

    trng_sync #(.NUM_OSC(NUM_OSC), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw_i(osc_i), .sync_o(osc_sync)
    );

    trng_sampler #(.NUM_OSC(NUM_OSC), .SAMPLE_CYCLES(SAMPLE_CYCLES)) u_sampler (
        .clk(clk), .rst(rst), .osc_i(osc_sync), .ebit_o(ebit)
    );

    trng_packer #(.WORD_W(WORD_W)) u_packer (
        .clk(clk), .rst(rst), .ebit_i(ebit), .clear_i(clear),
        .word_o(word), .ready_o(ready)
    );

    trng_regs #(.WORD_W(WORD_W)) u_regs (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
        .word_i(word), .ready_i(ready), .clear_o(clear), .rd_data(rd_data)
    );

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr) |=> !ready);
endmodule

// File: tb/sim_trng_collector.sv
module sim_trng_collector;
    localparam int unsigned NOSC = 32;
    localparam int unsigned NS   = 8;
    localparam int unsigned WW   = 32;
    localparam int unsigned SYN  = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NOSC-1:0] osc = '0;
    logic            rd_en = 1'b0;
    logic            rd_addr = 1'b0;
    logic [WW-1:0]   rd_data;

    int n_chk = 0;
    int n_bad = 0;
    int mode = 0;
    int ncyc = 0;

    trng_collector #(.NUM_OSC(NOSC), .SAMPLE_CYCLES(NS), .WORD_W(WW), .SYNC_STAGES(SYN)) u0 (
        .clk(clk), .rst(rst), .osc_i(osc), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    // Behavioural reference model, evaluated on each rising edge
    logic [NOSC-1:0] hist [SYN+1];
    int          m_tick;
    bit          m_second;
    bit          m_held;
    bit          m_bits [$];
    int          m_count;
    logic [WW-1:0] exp_rd = '0;

    function automatic logic [WW-1:0] model_word();
        logic [WW-1:0] w = '0;
        for (int i = 0; i < m_bits.size(); i++) w = {w[WW-2:0], m_bits[i]};
        return w;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i <= SYN; i++) hist[i] = '0;
            m_tick = 0; m_second = 0; m_held = 0; m_count = 0;
            m_bits.delete();
            exp_rd = '0;
        end else begin
            logic [NOSC-1:0] used;
            bit got;
            bit nb;
            got = 0; nb = 0;
            for (int i = SYN; i >= 1; i--) hist[i] = hist[i-1];
            hist[0] = osc;
            used = hist[SYN];
            if (!rd_en) exp_rd = '0;
            else if (rd_addr) exp_rd = model_word();
            else exp_rd = (m_count >= WW) ? 32'd1 : 32'd0;
            if (m_tick == NS - 1) begin
                m_tick = 0;
                if (m_second) begin nb = m_held ^ (^used); got = 1; m_second = 0; end
                else begin m_held = ^used; m_second = 1; end
            end else m_tick++;
            if (rd_en && rd_addr) m_count = 0;
            if (got) begin
                m_bits.push_back(nb);
                if (m_bits.size() > WW) void'(m_bits.pop_front());
                if (m_count < WW) m_count++;
            end
        end
    end

    // Per-clock comparison against the model (R8 read timing, R4 word content)
    always @(negedge clk) begin
        if (!rst) begin
            n_chk++;
            if (rd_data !== exp_rd) begin
                n_bad++;
                $display("FAIL R8 model compare: actual %h expected %h", rd_data, exp_rd);
            end
        end
    end

    // Oscillator stimulus
    always @(negedge clk) begin
        ncyc++;
        case (mode)
            0: osc <= '0;
            1: osc <= 32'h0000_0001;
            2: osc <= $urandom;
            default: osc <= ((ncyc / NS) % 2 == 1) ? 32'h0000_0700 : 32'h0000_0300;
        endcase
    end

    task automatic check(input string tag, input logic [WW-1:0] act, input logic [WW-1:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic rd(input logic a, output logic [WW-1:0] v);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        v = rd_data;
        rd_en = 1'b0; rd_addr = 1'b0;
    endtask

    task automatic wait_bits(input int nbits);
        repeat (nbits * 2 * NS) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [WW-1:0] v;
        logic [WW-1:0] w1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(1'b0, v); check("R1 status after reset", v, 32'd0);
        rd(1'b1, v); check("R1 data after reset", v, 32'd0);

        // R3 zero vector for a full word: word stays zero
        mode = 0;
        wait_bits(34);
        rd(1'b0, v); check("R5 ready after 32 bits", v, 32'd1);
        rd(1'b0, v); check("R8 status read keeps ready", v, 32'd1);
        rd(1'b1, v); check("R3 zero oscillators give zero word", v, 32'd0);
        rd(1'b0, v); check("R6 ready cleared by data read", v, 32'd0);

        // R3 constant odd parity cancels in each pair
        mode = 1;
        wait_bits(40);
        rd(1'b1, v); check("R3 constant parity gives zero word", v, 32'd0);

        // R3 parity flipping every interval gives all ones
        mode = 3;
        wait_bits(40);
        rd(1'b1, v); check("R4 alternating parity fills word with ones", v, 32'hFFFF_FFFF);

        // R6 fewer than 32 bits after a read is not ready
        wait_bits(30);
        rd(1'b0, v); check("R6 not ready after 30 bits", v, 32'd0);
        wait_bits(3);
        rd(1'b0, v); check("R6 ready again after 32 bits", v, 32'd1);

        // R7 continued collection while ready, flag held
        mode = 2;
        wait_bits(45);
        rd(1'b0, v); check("R7 ready held while collecting", v, 32'd1);
        rd(1'b1, w1); check("R4 random data word matches model", w1, exp_rd);
        rd(1'b0, v); check("R6 cleared after random read", v, 32'd0);

        // R2 random patterns over several words
        for (int k = 0; k < 4; k++) begin
            wait_bits(33);
            rd(1'b0, v); check("R2 ready per random word", v, 32'd1);
            rd(1'b1, v); check("R2 random word matches model", v, exp_rd);
        end

        // R1 reset mid-run clears word and flag
        wait_bits(33);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(1'b0, v); check("R1 status after second reset", v, 32'd0);
        rd(1'b1, v); check("R1 data after second reset", v, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule